// File: doc/BRIEF.md
# Lane Execution Mask Unit

This block keeps the per-lane enable mask for a group of vector lanes that all follow one scalar instruction stream. Each bit of the mask turns one lane on or off. The block carries out the scalar mask operations that structured control flow compiles into, and it has no predicate stack of its own. An if-region is entered with an AND-and-save, and the else-lanes are then formed with an XOR. An else-region is entered with an OR-and-save followed by an XOR into the mask. A join ORs saved lanes back into the mask. A loop exit clears the breaking lanes with AND-NOT and branches back while any lane is still live. Nesting costs nothing in hardware, because each save hands the old mask to a scalar register chosen by the caller.

Each cycle one opcode is applied together with a lane-compare mask and a saved-mask operand. Every operation finishes in a single cycle. The new mask, the scalar result with its write strobe, the zero and non-zero flags of the new mask, and a branch-taken flag all appear on registered outputs after the same clock edge.

Top module: `lane_mask_unit`

## Requirements
- R1: While `rst` is high, at each clock edge `exec_mask` becomes all ones, `res_we` and `branch_taken` become 0, `mask_zero` becomes 0 and `mask_nonzero` becomes 1.
- R2: Opcode 1 (AND-save) writes the old mask to `res_data` with `res_we`=1, and sets the mask to the old mask AND `cmp_mask`.
- R3: Opcode 2 (OR-save) writes the old mask to `res_data` with `res_we`=1, and sets the mask to the old mask OR `save_in`.
- R4: Opcode 3 (XOR to result) writes `save_in` XOR the mask to `res_data` with `res_we`=1, and leaves the mask unchanged.
- R5: Opcode 4 (XOR into mask) sets the mask to the mask XOR `save_in`, with `res_we`=0.
- R6: Opcode 5 (join) sets the mask to the mask OR `save_in`, with `res_we`=0.
- R7: Opcode 6 (loop exit) sets the mask to the mask AND NOT `save_in`, and sets `branch_taken` to 1 exactly when the new mask is non-zero.
- R8: Opcode 7 (skip if empty) sets `branch_taken` to 1 exactly when the current mask is all zero, and leaves the mask unchanged.
- R9: Opcode 8 (branch if live) sets `branch_taken` to 1 exactly when the current mask is non-zero, and leaves the mask unchanged.
- R10: Opcode 9 (load) replaces the mask with `save_in`, with `res_we`=0.
- R11: Opcode 10 (break accumulate) writes the mask OR `save_in` to `res_data` with `res_we`=1, and leaves the mask unchanged.
- R12: `mask_zero` and `mask_nonzero` describe the mask that is updated at the same edge: exactly one of them is 1, and `mask_zero` is 1 only when `exec_mask` is all zero.
- R13: Opcode 0 and opcodes 11 to 15 leave the mask unchanged, with `res_we`=0 and `branch_taken`=0.
- R14: The sequence if (AND-save, XOR to result), else (OR-save, XOR into mask) and join returns the mask to its value before the if. During the then-region only the compare lanes are active, and during the else-region only the other lanes are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Mask operation for this cycle |
| cmp_mask | input | LANES | Per-lane compare result |
| save_in | input | LANES | Saved-mask / scalar operand |
| exec_mask | output | LANES | Registered lane enable mask |
| res_data | output | LANES | Registered scalar result |
| res_we | output | 1 | Scalar result write strobe |
| mask_zero | output | 1 | New mask is all zero |
| mask_nonzero | output | 1 | New mask has a live lane |
| branch_taken | output | 1 | Branch condition of this operation held |

## Verification
The bench builds the block with its default values: 64 lanes and 8-lane zero-detect chunks. With these values the top lane (bit 63) and lane 0 can each be the only live lane, so a single set bit is seen through the last chunk and the first chunk of the zero-detect tree. The 64-lane width also lets a full if/else/join round trip and a two-step loop drain be checked with patterns that differ between chunks.

// File: rtl/lane_mask_pkg.sv
package lane_mask_pkg;

  typedef enum logic [3:0] {
    LM_NOP       = 4'd0,
    LM_AND_SAVE  = 4'd1,
    LM_OR_SAVE   = 4'd2,
    LM_XOR_RES   = 4'd3,
    LM_XOR_MASK  = 4'd4,
    LM_JOIN      = 4'd5,
    LM_LOOP_EXIT = 4'd6,
    LM_SKIP_ZERO = 4'd7,
    LM_BR_NZ     = 4'd8,
    LM_LOAD      = 4'd9,
    LM_BREAK_ACC = 4'd10
  } lm_op_e;

  // which condition drives branch_taken for an operation
  typedef enum logic [1:0] {
    BK_NONE    = 2'd0,
    BK_NEXT_NZ = 2'd1,
    BK_CUR_Z   = 2'd2,
    BK_CUR_NZ  = 2'd3
  } lm_brk_e;

endpackage

// File: rtl/lane_zero_detect.sv
module lane_zero_detect #(
  parameter int LANES = 64,
  parameter int CHUNK = 8
) (
  input  logic [LANES-1:0] vec,
  output logic             any_set
);
  localparam int NCH  = (LANES + CHUNK - 1) / CHUNK;
  localparam int PADW = NCH * CHUNK;

  logic [PADW-1:0] padded;
  logic [NCH-1:0]  chunk_any;

  always_comb begin
    padded = '0;
    padded[LANES-1:0] = vec;
  end

  // first level: one OR per chunk of lanes
  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    assign chunk_any[g] = |padded[g*CHUNK +: CHUNK];
  end

  assign any_set = |chunk_any;
endmodule

// File: rtl/lane_mask_alu.sv
module lane_mask_alu
  import lane_mask_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic [3:0]       op,
  input  logic [LANES-1:0] cur_mask,
  input  logic [LANES-1:0] cmp_mask,
  input  logic [LANES-1:0] save_in,
  output logic [LANES-1:0] nxt_mask,
  output logic [LANES-1:0] res_val,
  output logic             res_en,
  output lm_brk_e          br_kind
);
  always_comb begin
    nxt_mask = cur_mask;
    res_val  = '0;
    res_en   = 1'b0;
    br_kind  = BK_NONE;
    case (op)
      LM_AND_SAVE: begin
        res_val  = cur_mask;
        res_en   = 1'b1;
        nxt_mask = cur_mask & cmp_mask;
      end
      LM_OR_SAVE: begin
        res_val  = cur_mask;
        res_en   = 1'b1;
        nxt_mask = cur_mask | save_in;
      end
      LM_XOR_RES: begin
        res_val  = save_in ^ cur_mask;
        res_en   = 1'b1;
      end
      LM_XOR_MASK:  nxt_mask = cur_mask ^ save_in;
      LM_JOIN:      nxt_mask = cur_mask | save_in;
      LM_LOOP_EXIT: begin
        nxt_mask = cur_mask & ~save_in;
        br_kind  = BK_NEXT_NZ;
      end
      LM_SKIP_ZERO: br_kind = BK_CUR_Z;
      LM_BR_NZ:     br_kind = BK_CUR_NZ;
      LM_LOAD:      nxt_mask = save_in;
      LM_BREAK_ACC: begin
        res_val = cur_mask | save_in;
        res_en  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lane_mask_unit.sv
module lane_mask_unit
  import lane_mask_pkg::*;
#(
  parameter int LANES = 64,
  parameter int CHUNK = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_code,
  input  logic [LANES-1:0] cmp_mask,
  input  logic [LANES-1:0] save_in,
  output logic [LANES-1:0] exec_mask,
  output logic [LANES-1:0] res_data,
  output logic             res_we,
  output logic             mask_zero,
  output logic             mask_nonzero,
  output logic             branch_taken
);
  logic [LANES-1:0] nxt_mask;
  logic [LANES-1:0] res_val;
  logic             res_en;
  lm_brk_e          br_kind;
  logic             nxt_any;
  logic             taken_d;

  lane_mask_alu #(.LANES(LANES)) u_alu (
    .op       (op_code),
    .cur_mask (exec_mask),
    .cmp_mask (cmp_mask),
    .save_in  (save_in),
    .nxt_mask (nxt_mask),
    .res_val  (res_val),
    .res_en   (res_en),
    .br_kind  (br_kind)
  );

  lane_zero_detect #(.LANES(LANES), .CHUNK(CHUNK)) u_zdet (
    .vec     (nxt_mask),
    .any_set (nxt_any)
  );

  // current-mask conditions come from the registered flags
  always_comb begin
    case (br_kind)
      BK_NEXT_NZ: taken_d = nxt_any;
      BK_CUR_Z:   taken_d = mask_zero;
      BK_CUR_NZ:  taken_d = mask_nonzero;
      default:    taken_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_mask    <= '1;
      res_data     <= '0;
      res_we       <= 1'b0;
      mask_zero    <= 1'b0;
      mask_nonzero <= 1'b1;
      branch_taken <= 1'b0;
    end else begin
      exec_mask    <= nxt_mask;
      res_we       <= res_en;
      if (res_en) res_data <= res_val;
      mask_zero    <= ~nxt_any;
      mask_nonzero <= nxt_any;
      branch_taken <= taken_d;
    end
  end
endmodule

// File: rtl/lane_mask_checker.sv
module lane_mask_checker #(
  parameter int LANES = 64
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op_code,
  input logic [LANES-1:0] cmp_mask,
  input logic [LANES-1:0] save_in,
  input logic [LANES-1:0] exec_mask,
  input logic [LANES-1:0] res_data,
  input logic             res_we,
  input logic             mask_zero,
  input logic             mask_nonzero,
  input logic             branch_taken
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (exec_mask == {LANES{1'b1}} && !res_we && !branch_taken && mask_nonzero && !mask_zero));

  assert_and_save_R2: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd1) |=> (res_we && res_data == $past(exec_mask)
                           && exec_mask == ($past(exec_mask) & $past(cmp_mask))));

  assert_or_save_R3: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd2) |=> (res_we && res_data == $past(exec_mask)
                           && exec_mask == ($past(exec_mask) | $past(save_in))));

  assert_join_R6: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd5) |=> (!res_we && exec_mask == ($past(exec_mask) | $past(save_in))));

  assert_loop_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd6) |=> (exec_mask == ($past(exec_mask) & ~$past(save_in))
                           && branch_taken == (exec_mask != '0)));

  assert_skip_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd7) |=> ($stable(exec_mask) && branch_taken == (exec_mask == '0)));

  assert_flags_R12: assert property (@(posedge clk) disable iff (rst)
    ($countones({mask_zero, mask_nonzero}) == 1) && (mask_zero == (exec_mask == '0)));

  assert_idle_R13: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd0 || op_code > 4'd10) |=> ($stable(exec_mask) && !res_we && !branch_taken));
endmodule

bind lane_mask_unit lane_mask_checker #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .op_code      (op_code),
  .cmp_mask     (cmp_mask),
  .save_in      (save_in),
  .exec_mask    (exec_mask),
  .res_data     (res_data),
  .res_we       (res_we),
  .mask_zero    (mask_zero),
  .mask_nonzero (mask_nonzero),
  .branch_taken (branch_taken)
);

// File: tb/sim_lane_mask_unit.sv
`timescale 1ns/1ps
module sim_lane_mask_unit;
  localparam int L = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op_code = 4'd0;
  logic [L-1:0] cmp_mask = '0;
  logic [L-1:0] save_in = '0;
  logic [L-1:0] exec_mask, res_data;
  logic         res_we, mask_zero, mask_nonzero, branch_taken;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lane_mask_unit #(.LANES(L), .CHUNK(8)) u0 (
    .clk(clk), .rst(rst), .op_code(op_code), .cmp_mask(cmp_mask), .save_in(save_in),
    .exec_mask(exec_mask), .res_data(res_data), .res_we(res_we),
    .mask_zero(mask_zero), .mask_nonzero(mask_nonzero), .branch_taken(branch_taken)
  );

  task automatic chk(input bit ok, input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, results are sampled at the next falling edge
  task automatic apply(input logic [3:0] op, input logic [L-1:0] cm, input logic [L-1:0] sv);
    op_code = op; cmp_mask = cm; save_in = sv;
    @(negedge clk);
    op_code = 4'd0; cmp_mask = '0; save_in = '0;
  endtask

  task automatic chk_flags(input string tag);
    chk(mask_zero == (exec_mask == '0) && mask_nonzero == (exec_mask != '0),
        tag, {62'd0, mask_zero, mask_nonzero}, {62'd0, exec_mask == '0, exec_mask != '0});
  endtask

  task automatic t_reset();
    chk(exec_mask == '1, "R1 mask", exec_mask, '1);
    chk(!res_we && !branch_taken && !mask_zero && mask_nonzero, "R1 flags",
        {60'd0, res_we, branch_taken, mask_zero, mask_nonzero}, 64'd1);
  endtask

  task automatic t_load_and_save();
    logic [L-1:0] a = 64'hF0F0_1234_8000_0001;
    logic [L-1:0] c = 64'h0FF0_FF00_8000_0003;
    apply(4'd9, '1, a);
    chk(exec_mask == a && !res_we, "R10 load", exec_mask, a);
    apply(4'd1, c, '1);
    chk(res_we && res_data == a, "R2 saved", res_data, a);
    chk(exec_mask == (a & c), "R2 mask", exec_mask, a & c);
    chk_flags("R12 after and-save");
  endtask

  task automatic t_if_else_join();
    logic [L-1:0] c1 = 64'h00FF_00FF_A5A5_0001;
    logic [L-1:0] m0, then_m, else_m;
    apply(4'd9, '0, 64'hFFFF_FFFF_0F0F_FFF1);
    m0 = 64'hFFFF_FFFF_0F0F_FFF1;
    apply(4'd1, c1, '0);                     // if
    chk(res_data == m0, "R2 if save", res_data, m0);
    then_m = m0 & c1;
    chk(exec_mask == then_m, "R14 then lanes", exec_mask, then_m);
    apply(4'd3, '0, m0);                     // form else lanes
    else_m = m0 & ~c1;
    chk(res_we && res_data == else_m, "R4 xor result", res_data, else_m);
    chk(exec_mask == then_m, "R4 mask kept", exec_mask, then_m);
    apply(4'd2, '0, else_m);                 // else: or-save
    chk(res_we && res_data == then_m, "R3 saved", res_data, then_m);
    chk(exec_mask == m0, "R3 mask", exec_mask, m0);
    apply(4'd4, '0, then_m);                 // drop lanes already run
    chk(exec_mask == else_m && !res_we, "R5 xor mask", exec_mask, else_m);
    chk(exec_mask == else_m, "R14 else lanes", exec_mask, else_m);
    apply(4'd5, '0, then_m);                 // join
    chk(exec_mask == m0 && !res_we, "R6 join", exec_mask, m0);
    chk(exec_mask == m0, "R14 restored", exec_mask, m0);
  endtask

  task automatic t_loop();
    logic [L-1:0] m = 64'hF0F0_F0F0_F0F0_F0F0;
    apply(4'd9, '0, m);
    apply(4'd6, '0, 64'hF000_0000_0000_00F0);
    m = m & ~64'hF000_0000_0000_00F0;
    chk(exec_mask == m, "R7 mask", exec_mask, m);
    chk(branch_taken == 1'b1, "R7 taken", {63'd0, branch_taken}, 64'd1);
    apply(4'd6, '0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(exec_mask == '0 && branch_taken == 1'b0, "R7 drained", {63'd0, branch_taken}, 64'd0);
    chk(mask_zero && !mask_nonzero, "R12 zero", {62'd0, mask_zero, mask_nonzero}, 64'd2);
  endtask

  task automatic t_branches();
    // mask is zero here
    apply(4'd7, '1, '1);
    chk(branch_taken && exec_mask == '0, "R8 skip empty", {63'd0, branch_taken}, 64'd1);
    apply(4'd8, '1, '1);
    chk(!branch_taken && exec_mask == '0, "R9 empty not taken", {63'd0, branch_taken}, 64'd0);
    apply(4'd9, '0, 64'h8000_0000_0000_0000);
    chk_flags("R12 top lane");
    apply(4'd8, '0, '0);
    chk(branch_taken, "R9 top lane live", {63'd0, branch_taken}, 64'd1);
    apply(4'd9, '0, 64'd1);
    apply(4'd7, '0, '0);
    chk(!branch_taken && exec_mask == 64'd1, "R8 lane0 not skipped", exec_mask, 64'd1);
  endtask

  task automatic t_break_acc();
    logic [L-1:0] m = 64'h0000_FFFF_0000_1111;
    logic [L-1:0] s = 64'h1000_0000_0F00_0001;
    apply(4'd9, '0, m);
    apply(4'd10, '0, s);
    chk(res_we && res_data == (m | s), "R11 result", res_data, m | s);
    chk(exec_mask == m, "R11 mask kept", exec_mask, m);
  endtask

  task automatic t_idle();
    logic [L-1:0] m = 64'h0123_4567_89AB_CDEF;
    apply(4'd9, '0, m);
    apply(4'd1, '1, '1);                     // leaves res_data = m
    apply(4'd9, '0, m);
    for (int op = 11; op < 16; op++) begin
      apply(op[3:0], '1, '1);
      chk(exec_mask == m && !res_we && !branch_taken, "R13 unused code", exec_mask, m);
    end
    apply(4'd0, '1, '1);
    chk(exec_mask == m && !res_we && !branch_taken, "R13 nop", exec_mask, m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load_and_save();
    t_if_else_join();
    t_loop();
    t_branches();
    t_break_acc();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule